// File: doc/BRIEF.md
# Age-Ordered Reorder Window Scheduler

This block keeps every in-flight micro-op of an N-wide core in one circular window of W slots and schedules directly from it. There is no separate issue queue. Renamed micro-ops enter at the tail, up to N per cycle. Each cycle the block walks the window from the head toward the tail and picks up to N entries that have not issued yet and whose operands are ready. It gives each picked entry a countdown equal to its execution latency, and retires finished entries from the head strictly in program order.

An external scoreboard supplies one operand-readiness bit per window slot. A hit/miss flag travels with each load, so its latency is known when it issues. A mode input selects how loads are ordered against older stores. A separate switch forces in-order issue. A branch marked as mispredicted freezes enqueue until it has issued and a fixed restart delay has elapsed.

Within one cycle, retirement is evaluated first, then selection, then enqueue. A slot freed by retirement can therefore be refilled in the same cycle. A newly written micro-op is first visible to selection one cycle later.

Top module: `rob_sched`

## Requirements
- R1: While reset is held low and right after it is released, occupancy is 0, no issue lane is valid, commit_cnt is 0 and fetch_stall is 0.
- R2: Enqueue accepts a prefix of the valid input lanes, at most WIDTH, into consecutive slots starting at the tail; slot numbers begin at 0 after reset and wrap modulo DEPTH. Acceptance stops once the window is full. Space freed by retirement in the same cycle counts as free.
- R3: Each cycle, up to WIDTH entries are selected for issue; they are the oldest (counted from the head, across wrap-around) entries that are unissued, have src_rdy set for their slot and pass the memory rule. Lane 0 carries the oldest pick, and lanes fill from 0 upward. A micro-op enqueued at edge t can issue no earlier than the cycle after t.
- R4: An entry issued in cycle t is done from cycle t+L, where L is 1 for a non-load, 2 for a load with in_hit=1 and 9 for a load with in_hit=0. Retirement removes up to WIDTH done entries from the head per cycle and stops at the first entry that is not done.
- R5: With mem_mode=0, loads ignore stores entirely.
- R6: With mem_mode=1, a load may not issue while any older store in the window is not done. A store that issues in cycle t with latency 1 releases the load in cycle t+1.
- R7: With mem_mode=2, a load is held only by older not-done stores whose in_addr equals its own.
- R8: With in_order=1, the age scan ends at the first unissued entry that is not ready. No younger entry issues in that cycle.
- R9: Accepting a lane with in_mispred=1 rejects all later lanes in that cycle and sets fetch_stall. While fetch_stall is 1, enq_accept is 0.
- R10: If that branch issues in cycle t with latency L, fetch_stall stays 1 through cycle t+L+2 and enqueue resumes in cycle t+L+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_mode | input | 2 | Load ordering: 0 free, 1 conservative, 2 same-address |
| in_order | input | 1 | Stop the issue scan at the first unissued entry that is not ready |
| in_valid | input | WIDTH | Micro-op present on each enqueue lane |
| in_load | input | WIDTH | Lane carries a load |
| in_store | input | WIDTH | Lane carries a store |
| in_hit | input | WIDTH | Load hits the data cache |
| in_mispred | input | WIDTH | Lane carries a mispredicted branch |
| in_addr | input | WIDTH*ADDR_W | Memory address per lane |
| src_rdy | input | DEPTH | Operand readiness per window slot, from the scoreboard |
| enq_accept | output | WIDTH | Lane accepted this cycle |
| issue_valid | output | WIDTH | Issue lane carries a selected entry |
| issue_slot | output | WIDTH*IDX_W | Window slot issued on each lane |
| commit_cnt | output | CNT_W | Entries retired this cycle |
| occupancy | output | OCC_W | Entries held in the window |
| fetch_stall | output | 1 | Enqueue is frozen by a mispredicted branch |

## Verification
Selection is exercised in several situations: with every slot ready, which shows plain oldest-first order; with scattered readiness across a wrapped head, which tells true age order apart from slot-number order; and with a blocked head in in-order mode, which separates the in-order scan from the out-of-order one. A store placed ahead of loads at equal and different addresses is run under each memory mode, so the three rules give three different issue cycles for the same stream. Latency is measured with a lone load miss and with paired ALU and hit operations by watching retirement, and the restart window is timed cycle by cycle around a single mispredicted branch.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [1:0] {
      MEM_FREE     = 2'd0,
      MEM_CONSERV  = 2'd1,
      MEM_SAMEADDR = 2'd2
   } mem_mode_e;

   localparam int LAT_W       = 4;
   localparam int LAT_ALU     = 1;
   localparam int LAT_HIT     = 2;
   localparam int MISS_EXTRA  = 7;
   localparam int RESTART_CYC = 3;

   function automatic logic [LAT_W-1:0] op_latency(input logic is_ld, input logic hit);
      if (!is_ld)
         return LAT_W'(LAT_ALU);
      else if (hit)
         return LAT_W'(LAT_HIT);
      else
         return LAT_W'(LAT_HIT + MISS_EXTRA);
   endfunction

endpackage

// File: rtl/rob_mem_gate.sv
module rob_mem_gate
   import rob_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 8
) (
   input  mem_mode_e               mode,
   input  logic [DEPTH-1:0]        is_load,
   input  logic [DEPTH-1:0]        pend_store,
   input  logic [DEPTH*ADDR_W-1:0] addr,
   output logic [DEPTH-1:0]        mem_ok
);

   // Position k is age order: 0 is the head (oldest).
   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic hold;
      always_comb begin
         hold = 1'b0;
         for (int j = 0; j < k; j++) begin
            if (pend_store[j]) begin
               if (mode == MEM_CONSERV)
                  hold = 1'b1;
               else if (mode == MEM_SAMEADDR &&
                        addr[j*ADDR_W +: ADDR_W] == addr[k*ADDR_W +: ADDR_W])
                  hold = 1'b1;
            end
         end
      end
      assign mem_ok[k] = !is_load[k] || !hold;
   end

endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 2,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]       cand,
   input  logic [DEPTH-1:0]       blk,
   input  logic                   in_order,
   output logic [WIDTH-1:0]       lane_valid,
   output logic [WIDTH*IDX_W-1:0] lane_age
);

   logic [DEPTH-1:0] sel;

   always_comb begin
      int  got;
      logic stop;
      got  = 0;
      stop = 1'b0;
      sel  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (!stop) begin
            if (cand[k] && got < WIDTH) begin
               sel[k] = 1'b1;
               got++;
            end else if (blk[k] && in_order) begin
               stop = 1'b1;
            end
         end
      end
   end

   always_comb begin
      int c;
      lane_valid = '0;
      lane_age   = '0;
      for (int l = 0; l < WIDTH; l++) begin
         c = 0;
         for (int k = 0; k < DEPTH; k++) begin
            if (sel[k]) begin
               if (c == l) begin
                  lane_valid[l] = 1'b1;
                  lane_age[l*IDX_W +: IDX_W] = IDX_W'(k);
               end
               c++;
            end
         end
      end
   end

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
   parameter int WIDTH = 2,
   localparam int CNT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] head_done,
   output logic [CNT_W-1:0] count
);

   always_comb begin
      int  n;
      logic go;
      n  = 0;
      go = 1'b1;
      for (int k = 0; k < WIDTH; k++) begin
         if (go && head_done[k])
            n++;
         else
            go = 1'b0;
      end
      count = CNT_W'(n);
   end

endmodule

// File: rtl/rob_sched.sv
module rob_sched
   import rob_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int WIDTH  = 2,
   parameter int ADDR_W = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int OCC_W = $clog2(DEPTH + 1),
   localparam int CNT_W = $clog2(WIDTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              mem_mode,
   input  logic                    in_order,
   input  logic [WIDTH-1:0]        in_valid,
   input  logic [WIDTH-1:0]        in_load,
   input  logic [WIDTH-1:0]        in_store,
   input  logic [WIDTH-1:0]        in_hit,
   input  logic [WIDTH-1:0]        in_mispred,
   input  logic [WIDTH*ADDR_W-1:0] in_addr,
   input  logic [DEPTH-1:0]        src_rdy,
   output logic [WIDTH-1:0]        enq_accept,
   output logic [WIDTH-1:0]        issue_valid,
   output logic [WIDTH*IDX_W-1:0]  issue_slot,
   output logic [CNT_W-1:0]        commit_cnt,
   output logic [OCC_W-1:0]        occupancy,
   output logic                    fetch_stall
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("rob_sched: DEPTH must be a power of two, at least 2");
   end
   if (WIDTH < 1 || WIDTH > DEPTH) begin : g_bad_width
      $error("rob_sched: WIDTH must lie in 1..DEPTH");
   end

   // Window storage, indexed by physical slot
   logic [DEPTH-1:0]  e_v, e_iss, e_ld, e_st, e_hit, e_mp;
   logic [ADDR_W-1:0] e_addr [DEPTH];
   logic [LAT_W-1:0]  e_rem  [DEPTH];
   logic [IDX_W-1:0]  head_q, tail_q;
   logic [OCC_W-1:0]  occ_q;
   logic              susp_q;
   logic [LAT_W-1:0]  rcnt_q;

   // Age-ordered view (position 0 = head)
   logic [DEPTH-1:0]        a_ld, a_pend, a_done, a_memok, a_cand, a_blk;
   logic [DEPTH*ADDR_W-1:0] a_addr;

   for (genvar k = 0; k < DEPTH; k++) begin : g_view
      logic [IDX_W-1:0] pos;
      logic             fin;
      assign pos   = head_q + IDX_W'(k);
      assign fin   = e_v[pos] && e_iss[pos] && (e_rem[pos] == '0);
      assign a_done[k] = fin;
      assign a_ld[k]   = e_v[pos] && e_ld[pos];
      assign a_pend[k] = e_v[pos] && e_st[pos] && !fin;
      assign a_addr[k*ADDR_W +: ADDR_W] = e_addr[pos];
      assign a_cand[k] = e_v[pos] && !e_iss[pos] && src_rdy[pos] && a_memok[k];
      assign a_blk[k]  = e_v[pos] && !e_iss[pos] && !(src_rdy[pos] && a_memok[k]);
   end

   rob_mem_gate #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_gate (
      .mode       (mem_mode_e'(mem_mode)),
      .is_load    (a_ld),
      .pend_store (a_pend),
      .addr       (a_addr),
      .mem_ok     (a_memok)
   );

   logic [WIDTH*IDX_W-1:0] lane_age;

   rob_pick #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_pick (
      .cand       (a_cand),
      .blk        (a_blk),
      .in_order   (in_order),
      .lane_valid (issue_valid),
      .lane_age   (lane_age)
   );

   logic [IDX_W-1:0] iss_pos [WIDTH];
   for (genvar l = 0; l < WIDTH; l++) begin : g_lane
      assign iss_pos[l] = head_q + lane_age[l*IDX_W +: IDX_W];
      assign issue_slot[l*IDX_W +: IDX_W] = iss_pos[l];
   end

   rob_retire #(.WIDTH(WIDTH)) u_ret (
      .head_done (a_done[WIDTH-1:0]),
      .count     (commit_cnt)
   );

   // Enqueue acceptance: a prefix of lanes, bounded by room and fetch state
   logic [CNT_W-1:0] enq_num;

   always_comb begin
      int   room;
      int   took;
      logic halt;
      room = DEPTH - int'(occ_q) + int'(commit_cnt);
      took = 0;
      halt = susp_q || (rcnt_q != '0);
      enq_accept = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (!halt && in_valid[i] && took < room) begin
            enq_accept[i] = 1'b1;
            took++;
            if (in_mispred[i])
               halt = 1'b1;
         end else begin
            halt = 1'b1;
         end
      end
      enq_num = CNT_W'(took);
   end

   assign fetch_stall = susp_q || (rcnt_q != '0);
   assign occupancy   = occ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_v    <= '0;
         e_iss  <= '0;
         e_ld   <= '0;
         e_st   <= '0;
         e_hit  <= '0;
         e_mp   <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            e_addr[i] <= '0;
            e_rem[i]  <= '0;
         end
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
         susp_q <= 1'b0;
         rcnt_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (e_v[i] && e_iss[i] && e_rem[i] != '0)
               e_rem[i] <= e_rem[i] - 1'b1;
         end
         for (int k = 0; k < WIDTH; k++) begin
            if (k < int'(commit_cnt))
               e_v[head_q + IDX_W'(k)] <= 1'b0;
         end
         if (rcnt_q != '0)
            rcnt_q <= rcnt_q - 1'b1;
         for (int l = 0; l < WIDTH; l++) begin
            if (issue_valid[l]) begin
               e_iss[iss_pos[l]] <= 1'b1;
               e_rem[iss_pos[l]] <= op_latency(e_ld[iss_pos[l]], e_hit[iss_pos[l]]) - 1'b1;
               if (e_mp[iss_pos[l]]) begin
                  susp_q <= 1'b0;
                  rcnt_q <= op_latency(e_ld[iss_pos[l]], e_hit[iss_pos[l]])
                            + LAT_W'(RESTART_CYC - 1);
               end
            end
         end
         for (int i = 0; i < WIDTH; i++) begin
            if (enq_accept[i]) begin
               e_v[tail_q + IDX_W'(i)]    <= 1'b1;
               e_iss[tail_q + IDX_W'(i)]  <= 1'b0;
               e_rem[tail_q + IDX_W'(i)]  <= '0;
               e_ld[tail_q + IDX_W'(i)]   <= in_load[i];
               e_st[tail_q + IDX_W'(i)]   <= in_store[i];
               e_hit[tail_q + IDX_W'(i)]  <= in_hit[i];
               e_mp[tail_q + IDX_W'(i)]   <= in_mispred[i];
               e_addr[tail_q + IDX_W'(i)] <= in_addr[i*ADDR_W +: ADDR_W];
               if (in_mispred[i])
                  susp_q <= 1'b1;
            end
         end
         head_q <= head_q + IDX_W'(commit_cnt);
         tail_q <= tail_q + IDX_W'(enq_num);
         occ_q  <= occ_q + OCC_W'(enq_num) - OCC_W'(commit_cnt);
      end
   end

endmodule

// File: rtl/rob_sched_chk.sv
module rob_sched_chk #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 2,
   localparam int OCC_W = $clog2(DEPTH + 1),
   localparam int CNT_W = $clog2(WIDTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] enq_accept,
   input logic [WIDTH-1:0] issue_valid,
   input logic [CNT_W-1:0] commit_cnt,
   input logic [OCC_W-1:0] occupancy,
   input logic             fetch_stall
);

   assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occupancy) <= DEPTH);

   assert_enq_prefix_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((enq_accept + 1'b1) & enq_accept) == '0);

   assert_occ_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> int'(occupancy) == int'($past(occupancy))
                + $countones($past(enq_accept)) - int'($past(commit_cnt)));

   assert_lane_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((issue_valid + 1'b1) & issue_valid) == '0);

   assert_retire_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(commit_cnt) <= WIDTH && commit_cnt <= occupancy);

   assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> enq_accept == '0);

endmodule

bind rob_sched rob_sched_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enq_accept  (enq_accept),
   .issue_valid (issue_valid),
   .commit_cnt  (commit_cnt),
   .occupancy   (occupancy),
   .fetch_stall (fetch_stall)
);

// File: tb/sim_rob_sched.sv
`timescale 1ns/1ps
module sim_rob_sched;

   localparam int DEPTH = 8;
   localparam int WIDTH = 2;
   localparam int ADDR_W = 8;
   localparam int IDX_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       mem_mode = 2'd0;
   logic             in_order = 1'b0;
   logic [1:0]       in_valid = '0, in_load = '0, in_store = '0, in_hit = '0, in_mispred = '0;
   logic [15:0]      in_addr = '0;
   logic [7:0]       src_rdy = '1;
   logic [1:0]       enq_accept, issue_valid;
   logic [5:0]       issue_slot;
   logic [1:0]       commit_cnt;
   logic [3:0]       occupancy;
   logic             fetch_stall;

   int tests = 0;
   int fails = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   rob_sched #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u0 (
      .clk(clk), .rst_n(rst_n), .mem_mode(mem_mode), .in_order(in_order),
      .in_valid(in_valid), .in_load(in_load), .in_store(in_store), .in_hit(in_hit),
      .in_mispred(in_mispred), .in_addr(in_addr), .src_rdy(src_rdy),
      .enq_accept(enq_accept), .issue_valid(issue_valid), .issue_slot(issue_slot),
      .commit_cnt(commit_cnt), .occupancy(occupancy), .fetch_stall(fetch_stall)
   );

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int slot(input int l);
      return int'(issue_slot[l*IDX_W +: IDX_W]);
   endfunction

   task automatic clr_in();
      in_valid = '0; in_load = '0; in_store = '0; in_hit = '0; in_mispred = '0; in_addr = '0;
   endtask

   task automatic lane(input int l, input bit ld, input bit st, input bit hit,
                       input bit mp, input int a);
      in_valid[l] = 1'b1; in_load[l] = ld; in_store[l] = st;
      in_hit[l] = hit; in_mispred[l] = mp; in_addr[l*8 +: 8] = 8'(a);
   endtask

   task automatic do_reset();
      clr_in();
      src_rdy = '1; mem_mode = 2'd0; in_order = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R1 occupancy in reset", occupancy, 0);
      chk("R1 fetch_stall in reset", fetch_stall, 0);
      #1 rst_n = 1'b1;
   endtask

   task automatic adv();
      @(negedge clk);
      clr_in();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
   end

   initial begin
      // ---------- reset state ----------
      do_reset();
      #1;
      chk("R1 occupancy after reset", occupancy, 0);
      chk("R1 issue after reset", issue_valid, 0);
      chk("R1 commit after reset", commit_cnt, 0);
      chk("R1 stall after reset", fetch_stall, 0);

      // ---------- ALU + load hit latency ----------
      lane(0, 0, 0, 0, 0, 0); lane(1, 1, 0, 1, 0, 0);
      #1 chk("R2 two lanes accepted", enq_accept, 3);
      chk("R3 nothing issues in enqueue cycle", issue_valid, 0);
      adv(); #1;
      chk("R3 both issue next cycle", issue_valid, 3);
      chk("R3 lane0 oldest slot", slot(0), 0);
      chk("R3 lane1 slot", slot(1), 1);
      adv(); #1;
      chk("R4 ALU done, hit load not yet", commit_cnt, 1);
      adv(); #1;
      chk("R4 hit load done after 2", commit_cnt, 1);
      adv(); #1;
      chk("R4 window empty", occupancy, 0);

      // ---------- load miss latency ----------
      do_reset();
      lane(0, 1, 0, 0, 0, 0);
      #1 chk("R2 miss load accepted", enq_accept, 1);
      adv(); #1;
      chk("R3 miss load issues", issue_valid, 1);
      for (int c = 2; c <= 9; c++) begin
         adv(); #1;
         chk("R4 miss load not done before 9", commit_cnt, 0);
      end
      adv(); #1;
      chk("R4 miss load retires at issue+9", commit_cnt, 1);

      // ---------- free memory mode ----------
      do_reset();
      mem_mode = 2'd0; src_rdy = 8'b1111_1110;
      lane(0, 0, 1, 0, 0, 5); lane(1, 1, 0, 1, 0, 5);
      adv(); #1;
      chk("R5 load passes unready store", issue_valid, 1);
      chk("R5 load slot", slot(0), 1);

      // ---------- conservative mode ----------
      do_reset();
      mem_mode = 2'd1; src_rdy = 8'b1111_1110;
      lane(0, 0, 1, 0, 0, 5); lane(1, 1, 0, 1, 0, 6);
      adv(); #1;
      chk("R6 load held by unissued store", issue_valid, 0);
      adv(); src_rdy = '1; #1;
      chk("R6 store issues alone", issue_valid, 1);
      chk("R6 store slot", slot(0), 0);
      adv(); #1;
      chk("R6 load issues after store done", issue_valid, 1);
      chk("R6 load slot", slot(0), 1);

      // ---------- same-address mode ----------
      do_reset();
      mem_mode = 2'd2; src_rdy = 8'b1111_1110;
      lane(0, 0, 1, 0, 0, 5); lane(1, 1, 0, 1, 0, 6);
      adv(); lane(0, 1, 0, 1, 0, 5); #1;
      chk("R7 different-address load issues", issue_valid, 1);
      chk("R7 different-address slot", slot(0), 1);
      chk("R2 third op accepted", enq_accept, 1);
      adv(); #1;
      chk("R7 same-address load held", issue_valid, 0);
      adv(); src_rdy = '1; #1;
      chk("R7 store issues, load still held", issue_valid, 1);
      chk("R7 store slot", slot(0), 0);
      adv(); #1;
      chk("R7 same-address load released", issue_valid, 1);
      chk("R7 released slot", slot(0), 2);

      // ---------- mispredicted branch ----------
      do_reset();
      lane(0, 0, 0, 0, 1, 0); lane(1, 0, 0, 0, 0, 0);
      #1 chk("R9 lanes after mispredict rejected", enq_accept, 1);
      adv(); lane(0, 0, 0, 0, 0, 0); #1;
      chk("R9 stall raised", fetch_stall, 1);
      chk("R9 enqueue blocked", enq_accept, 0);
      chk("R10 branch issues", issue_valid, 1);
      for (int c = 2; c <= 4; c++) begin
         adv(); lane(0, 0, 0, 0, 0, 0); #1;
         chk("R10 stall within restart window", fetch_stall, 1);
         chk("R10 no enqueue in window", enq_accept, 0);
      end
      adv(); lane(0, 0, 0, 0, 0, 0); #1;
      chk("R10 stall cleared at t+L+3", fetch_stall, 0);
      chk("R10 enqueue resumes", enq_accept, 1);

      // ---------- full window, wrap, age order, in-order ----------
      do_reset();
      src_rdy = '0;
      for (int c = 0; c < 4; c++) begin
         lane(0, 0, 0, 0, 0, 0); lane(1, 0, 0, 0, 0, 0);
         #1 chk("R2 fill accepted", enq_accept, 3);
         adv();
      end
      lane(0, 0, 0, 0, 0, 0); lane(1, 0, 0, 0, 0, 0);
      src_rdy = 8'b0000_0011;
      #1;
      chk("R2 full window rejects", enq_accept, 0);
      chk("R2 occupancy full", occupancy, 8);
      chk("R3 head pair issues", issue_valid, 3);
      adv();
      src_rdy = '0;
      lane(0, 0, 0, 0, 0, 0); lane(1, 0, 0, 0, 0, 0);
      #1;
      chk("R4 two retire", commit_cnt, 2);
      chk("R2 freed space refilled same cycle", enq_accept, 3);
      adv();
      src_rdy = 8'b0010_0001;
      #1;
      chk("R3 two picks across wrap", issue_valid, 3);
      chk("R3 older slot 5 on lane0", slot(0), 5);
      chk("R3 younger slot 0 on lane1", slot(1), 0);
      adv();
      in_order = 1'b1; src_rdy = 8'b0000_1000;
      #1;
      chk("R8 blocked head stops scan", issue_valid, 0);
      adv();
      src_rdy = 8'b0001_0100;
      #1;
      chk("R8 only head issues", issue_valid, 1);
      chk("R8 head slot", slot(0), 2);

      finish_run();
   end

endmodule